// File: doc/BRIEF.md
# Streaming CRC32-C Block Checker

This block sits in a storage data path and protects each fixed-size data block with a 32-bit CRC32-C. Data moves through as 32-bit beats with a valid strobe, a marker that opens a new block and a strobe on the final beat. The checksum accumulates as the beats pass, so the data is never held.

In generate mode (writes) the block reports the checksum of each finished block so that the surrounding logic can store it with the data. In verify mode (reads) the surrounding logic presents the checksum that was stored earlier. The block compares it with the freshly computed value. A difference means a silent data error, and the block then raises a request to read the block again from the mirror copy. The block only raises this request; the retry and the checksum storage belong to other logic. Each finished block also carries a length check. A final strobe on any beat other than the last beat of the block is reported as a protocol error.

Top module: `crc_block_guard`

## Requirements
- R1: The checksum is CRC32-C in reflected form: polynomial 0x82F63B78, initial value 0xFFFFFFFF, final XOR 0xFFFFFFFF. The bytes of a beat are consumed from bits 7:0 upward. Over 32 bytes this gives 0x8A9136AA for all zero bytes, 0x62A8AB43 for all 0xFF bytes, and 0x46DD794E for the bytes 0,1,...,31.
- R2: `res_valid` is high for exactly the one cycle after a valid beat that has `in_last` high, and low in every other cycle.
- R3: A block is BLOCK_BYTES/4 beats (1024 at the default 4096 bytes). In generate mode, `res_crc` gives the checksum of every beat of the block.
- R4: `mode_verify` and `stored_crc` are sampled on the final beat. In verify mode, if `stored_crc` equals the computed checksum, `res_silent_err` stays low.
- R5: In verify mode, if `stored_crc` differs from the computed checksum of a correctly sized block, `res_silent_err` (the mirror-read request) is high together with `res_valid`.
- R6: In generate mode, `res_silent_err` is low whatever value `stored_crc` has.
- R7: After each final beat the running checksum restarts by itself. A block that follows with no idle cycle and no start marker is checked correctly.
- R8: If the final beat is not beat number BLOCK_BYTES/4 (the block is too short or too long), `res_len_err` is high with `res_valid` and `res_silent_err` is low. `res_crc` still covers the beats received.
- R9: A valid beat with `in_start` high drops any partial block and counts as the first beat of a new block.
- R10: Cycles with `in_valid` low change nothing, whatever `in_data`, `in_start` and `in_last` carry.
- R11: Synchronous active-high `rst` clears `res_valid`, `res_crc`, both flags and any partial block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_verify | input | 1 | 1 = compare with stored checksum, 0 = generate only |
| in_valid | input | 1 | Beat qualifier |
| in_start | input | 1 | First beat of a new block |
| in_last | input | 1 | Final beat of the block |
| in_data | input | DATA_W | Beat payload, byte 0 in bits 7:0 |
| stored_crc | input | 32 | Checksum stored earlier for the block being read |
| res_valid | output | 1 | One-cycle result strobe |
| res_crc | output | 32 | Checksum of the finished block |
| res_silent_err | output | 1 | Checksum mismatch; request a read of the mirror copy |
| res_len_err | output | 1 | Final beat arrived on a wrong beat count |

## Verification
Two things can land in the same cycle: a block's final beat and the first beat of the next block, and a length fault together with a checksum mismatch. The bench sends blocks back to back with no idle cycle, and in verify mode it sends short and overlong blocks with a deliberately wrong stored checksum. It then expects a clean result for the second block and a length error with no mirror request for each faulty one. Every result is compared against a queue of expected entries, which the bench builds from its own bit-serial checksum model.

// File: rtl/crcv_pkg.sv
package crcv_pkg;
  localparam logic [31:0] CRC_POLY_REFL = 32'h82F6_3B78;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_XOROUT    = 32'hFFFF_FFFF;

  // one byte through the reflected register, LSB first
  function automatic logic [31:0] crc_byte_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int k = 0; k < 8; k++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/crcv_fold.sv
module crcv_fold
  import crcv_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [31:0]       crc_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [31:0]       crc_out
);
  localparam int LANES = DATA_W / 8;

  logic [31:0] chain [LANES+1];

  assign chain[0] = crc_in;

  // byte lanes chained low lane first
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign chain[g+1] = crc_byte_step(chain[g], data_in[8*g +: 8]);
  end

  assign crc_out = chain[LANES];
endmodule

// File: rtl/crcv_beat_track.sv
module crcv_beat_track #(
  parameter int BEATS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic beat,
  input  logic start,
  input  logic last,
  output logic len_bad
);
  localparam int CNT_W = $clog2(BEATS + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             over_q;
  logic [CNT_W-1:0] eff_cnt;
  logic             eff_over;

  // beats already taken before the current one
  assign eff_cnt  = start ? '0 : cnt_q;
  assign eff_over = start ? 1'b0 : over_q;
  assign len_bad  = eff_over || (eff_cnt != CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      over_q <= 1'b0;
    end else if (beat) begin
      if (last) begin
        cnt_q  <= '0;
        over_q <= 1'b0;
      end else if (eff_cnt == CNT_W'(BEATS)) begin
        cnt_q  <= eff_cnt;
        over_q <= 1'b1;
      end else begin
        cnt_q  <= eff_cnt + 1'b1;
        over_q <= eff_over;
      end
    end
  end
endmodule

// File: rtl/crc_block_guard.sv
module crc_block_guard
  import crcv_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_verify,
  input  logic              in_valid,
  input  logic              in_start,
  input  logic              in_last,
  input  logic [DATA_W-1:0] in_data,
  input  logic [31:0]       stored_crc,
  output logic              res_valid,
  output logic [31:0]       res_crc,
  output logic              res_silent_err,
  output logic              res_len_err
);
  localparam int BEATS = BLOCK_BYTES / (DATA_W / 8);

  logic [31:0] acc_q;
  logic [31:0] acc_seed;
  logic [31:0] acc_next;
  logic [31:0] final_crc;
  logic        len_bad;
  logic        fin;

  assign fin       = in_valid && in_last;
  assign acc_seed  = in_start ? CRC_SEED : acc_q;
  assign final_crc = acc_next ^ CRC_XOROUT;

  crcv_fold #(.DATA_W(DATA_W)) u_fold (
    .crc_in  (acc_seed),
    .data_in (in_data),
    .crc_out (acc_next)
  );

  crcv_beat_track #(.BEATS(BEATS)) u_track (
    .clk     (clk),
    .rst     (rst),
    .beat    (in_valid),
    .start   (in_start),
    .last    (in_last),
    .len_bad (len_bad)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= CRC_SEED;
    end else if (in_valid) begin
      acc_q <= in_last ? CRC_SEED : acc_next;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid      <= 1'b0;
      res_crc        <= '0;
      res_silent_err <= 1'b0;
      res_len_err    <= 1'b0;
    end else begin
      res_valid      <= fin;
      res_silent_err <= fin && mode_verify && !len_bad && (final_crc != stored_crc);
      res_len_err    <= fin && len_bad;
      if (fin) res_crc <= final_crc;
    end
  end
endmodule

// File: rtl/crc_block_guard_chk.sv
module crc_block_guard_chk #(
  parameter int DATA_W      = 32,
  parameter int BLOCK_BYTES = 4096
) (
  input logic clk,
  input logic rst,
  input logic mode_verify,
  input logic in_valid,
  input logic in_start,
  input logic in_last,
  input logic res_valid,
  input logic res_silent_err,
  input logic res_len_err
);
  localparam int BEATS = BLOCK_BYTES / (DATA_W / 8);
  localparam int CW    = $clog2(BEATS + 2);

  logic [CW-1:0] seen_q;
  logic [CW-1:0] seen_now;
  logic          exp_bad_q;

  // beat index of the current beat, saturating past the block size
  always_comb begin
    seen_now = in_start ? CW'(1) : ((seen_q == CW'(BEATS + 1)) ? seen_q : seen_q + 1'b1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= '0;
      exp_bad_q <= 1'b0;
    end else if (in_valid) begin
      seen_q <= in_last ? '0 : seen_now;
      if (in_last) exp_bad_q <= (seen_now != CW'(BEATS));
    end
  end

  // R2
  a_r2_valid_follows_last: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last) |=> res_valid);
  // R2
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && in_last) |=> !res_valid);
  // R6
  a_r6_generate_quiet: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_last && !mode_verify) |=> !res_silent_err);
  // R8
  a_r8_len_matches_count: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_len_err == exp_bad_q));
  // R8
  a_r8_len_masks_compare: assert property (@(posedge clk) disable iff (rst)
    res_len_err |-> !res_silent_err);
  // R10
  a_r10_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_silent_err && !res_len_err));
endmodule

bind crc_block_guard crc_block_guard_chk #(.DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .mode_verify    (mode_verify),
  .in_valid       (in_valid),
  .in_start       (in_start),
  .in_last        (in_last),
  .res_valid      (res_valid),
  .res_silent_err (res_silent_err),
  .res_len_err    (res_len_err)
);

// File: tb/crc_block_guard_test.sv
module crc_block_guard_test;
  localparam int BEATS = 1024;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        mode = 1'b0, vld = 1'b0, sta = 1'b0, lst = 1'b0;
  logic [31:0] dat = '0, refc = '0;
  logic        r_valid, r_silent, r_len;
  logic [31:0] r_crc;

  logic        s_vld = 1'b0, s_lst = 1'b0;
  logic [31:0] s_dat = '0;
  logic        s_valid, s_silent, s_len;
  logic [31:0] s_crc;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  crc_block_guard uut (
    .clk(clk), .rst(rst), .mode_verify(mode), .in_valid(vld), .in_start(sta),
    .in_last(lst), .in_data(dat), .stored_crc(refc), .res_valid(r_valid),
    .res_crc(r_crc), .res_silent_err(r_silent), .res_len_err(r_len)
  );

  crc_block_guard #(.DATA_W(32), .BLOCK_BYTES(32)) uut_short (
    .clk(clk), .rst(rst), .mode_verify(1'b0), .in_valid(s_vld), .in_start(1'b0),
    .in_last(s_lst), .in_data(s_dat), .stored_crc(32'd0), .res_valid(s_valid),
    .res_crc(s_crc), .res_silent_err(s_silent), .res_len_err(s_len)
  );

  typedef struct {
    logic [31:0] crc;
    bit          silent;
    bit          len_err;
    string       tag;
  } exp_t;

  exp_t sb[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bit-serial reference model, bytes taken low first
  function automatic logic [31:0] model_word(input logic [31:0] c, input logic [31:0] w);
    logic [31:0] r = c;
    for (int b = 0; b < 4; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (r[0] ^ w[8*b + k]) r = (r >> 1) ^ 32'h82F6_3B78;
        else                   r = r >> 1;
      end
    end
    return r;
  endfunction

  function automatic logic [31:0] word_of(input logic [31:0] seed, input int i);
    return (seed * 32'h9E37_79B1) ^ (i * 32'h85EB_CA77) ^ (32'(i) << 13);
  endfunction

  // driver: pushes the expected result when the final beat is sent
  task automatic drive_block(input logic [31:0] seed, input int nbeats, input bit use_last,
                             input bit verify, input bit bad_ref, input bit mark_start,
                             input bit gaps, input string tag);
    logic [31:0] m = 32'hFFFF_FFFF;
    logic [31:0] w;
    exp_t e;
    for (int i = 0; i < nbeats; i++) begin
      if (gaps && (i % 7) == 3) begin
        @(negedge clk);
        vld = 1'b0; lst = 1'b1; sta = 1'b1; dat = $urandom; refc = $urandom;
      end
      @(negedge clk);
      w = word_of(seed, i);
      m = model_word(m, w);
      vld = 1'b1; dat = w; mode = verify;
      sta = mark_start && (i == 0);
      lst = use_last && (i == nbeats - 1);
      if (lst) begin
        e.crc     = ~m;
        e.len_err = (nbeats != BEATS);
        e.silent  = verify && !e.len_err && bad_ref;
        e.tag     = tag;
        refc      = bad_ref ? (e.crc ^ 32'h0000_0100) : e.crc;
        sb.push_back(e);
      end else begin
        refc = $urandom;
      end
    end
  endtask

  task automatic go_idle(input int n);
    @(negedge clk);
    vld = 1'b0; lst = 1'b0; sta = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && r_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R2 unexpected result", {31'd0, r_valid}, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(r_crc === e.crc, {e.tag, " crc"}, r_crc, e.crc);
        check(r_silent === e.silent, {e.tag, " silent_err"}, {31'd0, r_silent}, {31'd0, e.silent});
        check(r_len === e.len_err, {e.tag, " len_err"}, {31'd0, r_len}, {31'd0, e.len_err});
      end
    end
  end

  task automatic short_vec(input int kind, input logic [31:0] exp, input string tag);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      s_vld = 1'b1;
      s_lst = (i == 7);
      case (kind)
        0: s_dat = 32'h0;
        1: s_dat = 32'hFFFF_FFFF;
        default: s_dat = {8'(4*i+3), 8'(4*i+2), 8'(4*i+1), 8'(4*i)};
      endcase
    end
    @(negedge clk);
    s_vld = 1'b0; s_lst = 1'b0;
    check(s_valid === 1'b1 && s_len === 1'b0 && s_silent === 1'b0, {tag, " strobe"},
          {29'd0, s_valid, s_len, s_silent}, 32'd4);
    check(s_crc === exp, tag, s_crc, exp);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(r_valid === 1'b0 && r_silent === 1'b0 && r_len === 1'b0, "R11 reset flags",
          {29'd0, r_valid, r_silent, r_len}, 32'd0);
    check(r_crc === 32'd0, "R11 reset crc", r_crc, 32'd0);

    // R1 known vectors on the 8-beat instance
    short_vec(0, 32'h8A91_36AA, "R1 zeros");
    short_vec(1, 32'h62A8_AB43, "R1 ones");
    short_vec(2, 32'h46DD_794E, "R1 ascending");

    drive_block(32'h1, BEATS, 1, 0, 0, 1, 0, "R3 generate");
    go_idle(3);
    drive_block(32'h2, BEATS, 1, 1, 0, 1, 0, "R4 verify match");
    go_idle(3);
    drive_block(32'h3, BEATS, 1, 1, 1, 1, 0, "R5 verify mismatch");
    go_idle(3);
    drive_block(32'h4, BEATS, 1, 0, 1, 1, 0, "R6 generate bad ref");
    go_idle(3);
    // R7 back to back, second block without start marker
    drive_block(32'h5, BEATS, 1, 1, 1, 1, 0, "R7 first");
    drive_block(32'h6, BEATS, 1, 1, 0, 0, 0, "R7 second");
    go_idle(3);
    // R8 short and long blocks with a wrong stored value
    drive_block(32'h7, 10, 1, 1, 1, 1, 0, "R8 short");
    go_idle(3);
    drive_block(32'h8, BEATS + 6, 1, 1, 1, 1, 0, "R8 long");
    go_idle(3);
    drive_block(32'h9, BEATS - 1, 1, 0, 0, 1, 0, "R8 one short");
    // R9 partial block dropped by a start marker
    drive_block(32'hA, 50, 0, 1, 0, 1, 0, "R9 partial");
    drive_block(32'hB, BEATS, 1, 1, 0, 1, 0, "R9 restart");
    go_idle(3);
    // R10 idle cycles carrying junk strobes
    drive_block(32'hC, BEATS, 1, 1, 1, 1, 1, "R10 gaps");
    go_idle(3);
    // R11 reset drops a partial block
    drive_block(32'hD, 500, 0, 1, 0, 1, 0, "R11 partial");
    @(negedge clk);
    vld = 1'b0; lst = 1'b0; sta = 1'b0; rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    drive_block(32'hE, BEATS, 1, 1, 0, 0, 0, "R11 after reset");
    go_idle(5);

    check(sb.size() == 0, "R2 missing results", 32'(sb.size()), 32'd0);
    finish_run();
  end
endmodule